// File: doc/BRIEF.md
# Two-Level Interrupt Controller Acknowledge Sequencer

This block joins two eight-line interrupt controller cores, a primary and a secondary, into one sixteen-line interrupt system with a single CPU interrupt line. A request is named by a 4-bit number. Bit 3 of that number picks the core and bits [2:0] pick the line inside that core. A rising edge on a request line latches it as pending. Whenever the secondary core has a request that can win, the block forwards it to primary input 2. The CPU interrupt line follows the primary core's winner.

Each core picks its winner by fixed priority, with line 0 highest. A line can win only if it is pending, not masked, and no line of equal or higher priority is in service.

The CPU takes interrupts in one of two ways:
- **Acknowledge cycle.** The primary winner is taken into service. If that winner is the cascade input (line 2), the secondary winner is also taken into service. The block then returns an 8-bit vector and the 16-line index.
- **Memory-mapped acknowledge read (poll).** This serves the same winner chain without putting anything in service. It returns the 16-line index and switches the status view to the primary in-service register.

Spurious cases return level 7 of the core that came up empty.

Top module: `pic_cascade_seq`

## Requirements
- R1: A request with `req_num[3]`=1 acts on secondary line `req_num[2:0]`, and with `req_num[3]`=0 on primary line `req_num[2:0]`. A 0-to-1 change of `req_level` on a line makes that line pending.
- R2: While the secondary core has a winning request, primary line 2 becomes pending one cycle later.
- R3: `cpu_int` is high exactly when the primary core has a winner. A winner is a pending, unmasked line with no in-service line of equal or higher priority (lower number is higher priority).
- R4: On `inta`, if the primary winner is line L with L other than 2, then one cycle later `ack_valid`=1, `ack_vector`={`base_m`,L} and `ack_line`=L.
- R5: On `inta`, if the primary winner is line 2 and the secondary winner is line S, then `ack_vector`={`base_s`,S} and `ack_line`=8+S. Both primary line 2 and secondary line S go into service.
- R6: On `inta`, if the primary winner is line 2 and the secondary core has no winner, then `ack_vector`={`base_s`,3'd7} and `ack_line`=15.
- R7: On `inta`, if the primary core has no winner, then `ack_vector`={`base_m`,3'd7} and `ack_line`=7.
- R8: `cpu_int` is re-evaluated after every acknowledge. It drops when no eligible request remains. It stays high when a higher-priority request became pending in the acknowledge cycle.
- R9: A poll (`mmio_ack`) with primary winner L other than 2 returns `poll_line`=L one cycle later and clears both the pending and in-service bits of L. With no primary winner it returns 7.
- R10: A poll whose primary winner is line 2 returns 8+S (15 if the secondary core has no winner). It clears primary line 2 and secondary line S. After any poll, `status` shows the primary in-service bits until `sel_irr` is pulsed. Otherwise `status` shows the primary pending bits.
- R11: `eoi_valid` with `eoi_num` clears the in-service bit of that 16-line index, using bit 3 as the core select.
- R12: When `inta` and `mmio_ack` arrive in the same cycle, only the acknowledge is performed. `poll_valid` stays 0 and the status view is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request line level update strobe |
| req_num | input | 4 | 16-line request number |
| req_level | input | 1 | New level of the addressed line |
| mask_m | input | 8 | Primary line masks |
| mask_s | input | 8 | Secondary line masks |
| base_m | input | 5 | Primary vector base (upper five bits) |
| base_s | input | 5 | Secondary vector base (upper five bits) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | 4 | 16-line index whose in-service bit is cleared |
| inta | input | 1 | CPU acknowledge strobe |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vector | output | 8 | Acknowledge vector |
| ack_line | output | 4 | 16-line index served by the acknowledge |
| mmio_ack | input | 1 | Memory-mapped acknowledge read strobe |
| poll_valid | output | 1 | Poll result valid |
| poll_line | output | 4 | 16-line index returned by the poll |
| sel_irr | input | 1 | Return the status view to the primary pending bits |
| status | output | 8 | Primary pending or in-service bits |
| cpu_int | output | 1 | Interrupt request to the CPU |

## Verification
The bench goes after the cascade corners:
- **Primary line 2 raised directly, with nothing behind it in the secondary core.** A design without spurious substitution would return a secondary level taken from stale data instead of 15.
- **Acknowledge with nothing pending.** A design that skipped substitution would return base plus 0.
- **A request arriving in the same cycle as an acknowledge.** This catches a `cpu_int` that is evaluated only before the acknowledge.
- **Colliding `inta` and `mmio_ack`.** This shows whether a design lets the poll clear state or flip the status view.
- **Masking and in-service blocking.** A design that ignored either would raise `cpu_int` for a request that must not win.

// File: rtl/pic_cascade_seq.sv
module pic_cascade_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_num,
  input  logic       req_level,
  input  logic [7:0] mask_m,
  input  logic [7:0] mask_s,
  input  logic [4:0] base_m,
  input  logic [4:0] base_s,
  input  logic       eoi_valid,
  input  logic [3:0] eoi_num,
  input  logic       inta,
  output logic       ack_valid,
  output logic [7:0] ack_vector,
  output logic [3:0] ack_line,
  input  logic       mmio_ack,
  output logic       poll_valid,
  output logic [3:0] poll_line,
  input  logic       sel_irr,
  output logic [7:0] status,
  output logic       cpu_int
);

  localparam logic [2:0] CASC = 3'd2;
  localparam logic [2:0] SPUR = 3'd7;

  logic [7:0] m_irr, m_isr, m_last, s_irr, s_isr, s_last;
  logic [7:0] m_irr_n, m_isr_n, m_last_n, s_irr_n, s_isr_n, s_last_n;
  logic       rdsel_isr;
  logic       m_hit, s_hit;
  logic [2:0] m_idx, s_idx;
  logic       do_poll;

  function automatic logic [3:0] pick(input logic [7:0] irr, input logic [7:0] isr,
                                      input logic [7:0] imr);
    logic       blk, hit;
    logic [2:0] idx;
    blk = 1'b0;
    hit = 1'b0;
    idx = 3'd0;
    for (int i = 0; i < 8; i++) begin
      blk = blk | isr[i];
      if (!blk && !hit && irr[i] && !imr[i]) begin
        hit = 1'b1;
        idx = 3'(i);
      end
    end
    return {hit, idx};
  endfunction

  assign {m_hit, m_idx} = pick(m_irr, m_isr, mask_m);
  assign {s_hit, s_idx} = pick(s_irr, s_isr, mask_s);
  assign cpu_int = m_hit;
  assign do_poll = mmio_ack && !inta;
  assign status  = rdsel_isr ? m_isr : m_irr;

  always_comb begin
    m_irr_n = m_irr; m_isr_n = m_isr; m_last_n = m_last;
    s_irr_n = s_irr; s_isr_n = s_isr; s_last_n = s_last;
    if (req_valid) begin
      if (req_num[3]) begin
        if (req_level && !s_last[req_num[2:0]]) s_irr_n[req_num[2:0]] = 1'b1;
        s_last_n[req_num[2:0]] = req_level;
      end else begin
        if (req_level && !m_last[req_num[2:0]]) m_irr_n[req_num[2:0]] = 1'b1;
        m_last_n[req_num[2:0]] = req_level;
      end
    end
    if (s_hit) m_irr_n[CASC] = 1'b1;
    if (eoi_valid) begin
      if (eoi_num[3]) s_isr_n[eoi_num[2:0]] = 1'b0;
      else            m_isr_n[eoi_num[2:0]] = 1'b0;
    end
    if (inta) begin
      if (m_hit) begin
        m_irr_n[m_idx] = 1'b0;
        m_isr_n[m_idx] = 1'b1;
        if (m_idx == CASC && s_hit) begin
          s_irr_n[s_idx] = 1'b0;
          s_isr_n[s_idx] = 1'b1;
        end
      end
    end else if (mmio_ack) begin
      if (m_hit) begin
        m_irr_n[m_idx] = 1'b0;
        m_isr_n[m_idx] = 1'b0;
        if (m_idx == CASC && s_hit) begin
          s_irr_n[s_idx] = 1'b0;
          s_isr_n[s_idx] = 1'b0;
        end
      end
    end
  end

  logic [7:0] vec_n;
  logic [3:0] line_n;
  always_comb begin
    if (m_hit && m_idx != CASC) begin
      vec_n  = {base_m, m_idx};
      line_n = {1'b0, m_idx};
    end else if (m_hit) begin
      vec_n  = {base_s, s_hit ? s_idx : SPUR};
      line_n = {1'b1, s_hit ? s_idx : SPUR};
    end else begin
      vec_n  = {base_m, SPUR};
      line_n = {1'b0, SPUR};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_irr <= '0; m_isr <= '0; m_last <= '0;
      s_irr <= '0; s_isr <= '0; s_last <= '0;
      rdsel_isr  <= 1'b0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
      ack_line   <= '0;
      poll_valid <= 1'b0;
      poll_line  <= '0;
    end else begin
      m_irr <= m_irr_n; m_isr <= m_isr_n; m_last <= m_last_n;
      s_irr <= s_irr_n; s_isr <= s_isr_n; s_last <= s_last_n;
      ack_valid  <= inta;
      poll_valid <= do_poll;
      if (inta) begin
        ack_vector <= vec_n;
        ack_line   <= line_n;
      end
      if (do_poll) begin
        poll_line <= line_n;
        rdsel_isr <= 1'b1;
      end else if (sel_irr) begin
        rdsel_isr <= 1'b0;
      end
    end
  end

  // R2
  cascade_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && !inta && !mmio_ack) |=> m_irr[2]);
  // R3
  int_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((m_irr & ~mask_m) != 8'h00));
  // R4
  prim_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && m_hit && m_idx != 3'd2) |=> (ack_valid && ack_line == {1'b0, $past(m_idx)}));
  // R5
  sec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && m_hit && m_idx == 3'd2 && s_hit) |=> (ack_line == {1'b1, $past(s_idx)}));
  // R6
  sec_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && m_hit && m_idx == 3'd2 && !s_hit) |=> (ack_line == 4'd15));
  // R7
  prim_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !m_hit) |=> (ack_vector == {$past(base_m), 3'd7}));
  // R10
  poll_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_ack && !inta) |=> rdsel_isr);
  // R12
  ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> !poll_valid);

endmodule

// File: tb/pic_cascade_seq_bench.sv
module pic_cascade_seq_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_num = '0;
  logic       req_level = 1'b0;
  logic [7:0] mask_m = '0, mask_s = '0;
  logic [4:0] base_m = 5'd1, base_s = 5'd14;
  logic       eoi_valid = 1'b0;
  logic [3:0] eoi_num = '0;
  logic       inta = 1'b0, mmio_ack = 1'b0, sel_irr = 1'b0;
  logic       ack_valid, poll_valid, cpu_int;
  logic [7:0] ack_vector, status;
  logic [3:0] ack_line, poll_line;

  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  pic_cascade_seq u_pic_cascade_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
    .req_level(req_level), .mask_m(mask_m), .mask_s(mask_s), .base_m(base_m),
    .base_s(base_s), .eoi_valid(eoi_valid), .eoi_num(eoi_num), .inta(inta),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_line(ack_line),
    .mmio_ack(mmio_ack), .poll_valid(poll_valid), .poll_line(poll_line),
    .sel_irr(sel_irr), .status(status), .cpu_int(cpu_int));

  // line, expected vector, expected 16-line index
  localparam logic [15:0] VEC [10] = '{
    {4'd0,  8'h08, 4'd0},  {4'd1,  8'h09, 4'd1},  {4'd3,  8'h0B, 4'd3},
    {4'd7,  8'h0F, 4'd7},  {4'd8,  8'h70, 4'd8},  {4'd10, 8'h72, 4'd10},
    {4'd15, 8'h77, 4'd15}, {4'd2,  8'h77, 4'd15}, {4'd5,  8'h0D, 4'd5},
    {4'd12, 8'h74, 4'd12}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic raise(input logic [3:0] n);
    @(negedge clk); req_valid = 1'b1; req_num = n; req_level = 1'b1;
    @(negedge clk); req_level = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic do_poll;
    @(negedge clk); mmio_ack = 1'b1;
    @(negedge clk); mmio_ack = 1'b0;
  endtask

  task automatic eoi(input logic [3:0] n);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = n;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset cpu_int", cpu_int, 0);
    chk("reset ack_valid", ack_valid, 0);
    chk("reset poll_valid", poll_valid, 0);
    chk("reset status", status, 0);

    // R7 spurious acknowledge on an idle primary
    do_ack;
    chk("R7 vector", ack_vector, 8'h0F);
    chk("R7 line", ack_line, 7);

    // R1 R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < 10; i++) begin
      logic [3:0] ln, el; logic [7:0] ev;
      {ln, ev, el} = VEC[i];
      raise(ln);
      chk($sformatf("R2/R3 cpu_int line %0d", ln), cpu_int, 1);
      do_ack;
      chk($sformatf("R4/R5/R6 ack_valid line %0d", ln), ack_valid, 1);
      chk($sformatf("R4/R5/R6 vector line %0d", ln), ack_vector, ev);
      chk($sformatf("R4/R5/R6 index line %0d", ln), ack_line, el);
      eoi(el);
      if (el[3]) eoi(4'd2);
      chk($sformatf("R11 idle after line %0d", ln), cpu_int, 0);
    end

    // R1 R3 masking and routing
    mask_m = 8'h20;
    raise(4'd5);
    chk("R1 primary pending bit 5", status, 8'h20);
    chk("R3 masked no cpu_int", cpu_int, 0);
    mask_m = 8'h00;
    @(negedge clk);
    chk("R3 unmasked cpu_int", cpu_int, 1);
    do_ack; eoi(4'd5);
    mask_s = 8'h08;
    raise(4'd11);
    chk("R1 masked secondary line not cascaded", status, 8'h00);
    mask_s = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1 secondary routed to cascade", status, 8'h04);
    do_ack; eoi(4'd11); eoi(4'd2);

    // R8 re-evaluation after acknowledge
    raise(4'd5);
    do_ack;
    chk("R8 drop after ack", cpu_int, 0);
    @(negedge clk); inta = 1'b1; req_valid = 1'b1; req_num = 4'd1; req_level = 1'b1;
    @(negedge clk); inta = 1'b0; req_level = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    chk("R8 held after ack", cpu_int, 1);
    do_ack;
    chk("R8 vector", ack_vector, 8'h09);
    eoi(4'd1); eoi(4'd5);
    chk("R11 idle", cpu_int, 0);

    // R11 in-service blocking and release
    raise(4'd4); do_ack;
    raise(4'd6);
    chk("R3 blocked by in-service", cpu_int, 0);
    eoi(4'd4);
    @(negedge clk);
    chk("R11 released", cpu_int, 1);
    do_ack;
    chk("R11 vector", ack_vector, 8'h0E);
    eoi(4'd6);

    // R9 poll
    raise(4'd6); do_poll;
    chk("R9 poll_valid", poll_valid, 1);
    chk("R9 poll line", poll_line, 6);
    chk("R9 cleared", cpu_int, 0);
    chk("R10 status shows in-service", status, 8'h00);
    do_poll;
    chk("R9 spurious poll", poll_line, 7);

    // R10 cascaded poll
    @(negedge clk); sel_irr = 1'b1; @(negedge clk); sel_irr = 1'b0;
    raise(4'd11);
    chk("R10 cascade pending", status, 8'h04);
    do_poll;
    chk("R10 poll line", poll_line, 11);
    chk("R10 in-service view", status, 8'h00);
    @(negedge clk); sel_irr = 1'b1; @(negedge clk); sel_irr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 cascade cleared", status, 8'h00);
    chk("R10 no cpu_int", cpu_int, 0);
    do_poll;
    chk("R10 empty secondary poll", poll_line, 7);
    @(negedge clk); sel_irr = 1'b1; @(negedge clk); sel_irr = 1'b0;

    // R12 collision
    raise(4'd4);
    @(negedge clk); inta = 1'b1; mmio_ack = 1'b1;
    @(negedge clk); inta = 1'b0; mmio_ack = 1'b0;
    chk("R12 ack taken", ack_vector, 8'h0C);
    chk("R12 poll ignored", poll_valid, 0);
    chk("R12 view unchanged", status, 8'h00);
    eoi(4'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule